// File: doc/BRIEF.md
# Adaptive Luma/Chroma Separator

This block splits a composite video sample stream, one unsigned sample per clock at four times the colour subcarrier, into a luma stream and a chroma stream. It keeps one video line of past samples in a memory. With that line it forms a vertical comb result, in which the line-to-line inversion of the chroma phase cancels chroma from luma. A five-tap horizontal bandpass around the subcarrier gives a second result. A two-bit mode input chooses how the two outputs are formed. In adaptive mode a vertical correlation detector picks comb or bandpass for each sample. The other modes force bandpass or comb, or pass the composite straight to the luma output.

An optional peaking stage sharpens the selected luma. Both outputs leave the block a fixed number of clocks after the input sample they belong to, whatever the mode, so the two streams stay aligned. Chroma is signed inside the block and is put out as offset binary.

Top module: `yc_separator`

## Requirements
- R1: A synchronous reset drives y_out to 0 and c_out to 128 and clears the pipeline. Until a full line has been written after reset, the line memory reads as 0.
- R2: The luma and chroma results for input sample m appear on y_out and c_out exactly LATENCY (default 17) clocks after the clock edge that captured x[m], in every mode.
- R3: c_out carries the chroma value c in offset binary: c_out = c + 128, where c is in -128..127.
- R4: With mode = 2'b01 (bandpass), c = (2x[m] - x[m-2] - x[m+2]) >>> 2 and y = clip(x[m] - c) to 0..255. Peaking has no effect in this mode.
- R5: With mode = 2'b11 (comb), c = (x[m] - u[m]) >>> 1 and y = (x[m] + u[m]) >> 1, where u[m] = x[m-LINE_LEN].
- R6: With mode = 2'b10 (luma pass-through), y before peaking is x[m], and c is the chroma that adaptive mode would give.
- R7: With mode = 2'b00 (adaptive), let d[i] = x[i] - u[i] and v = (d[m-2] + 2d[m] + d[m+2]) >>> 2. When |v| < thr, the comb results of R5 are used. Otherwise the bandpass results of R4 are used. thr = 0 therefore always selects bandpass.
- R8: With peak_en = 1 and any mode other than 2'b01, y_out = clip(y[k] + ((2y[k] - y[k-1] - y[k+1]) >>> 2)) to 0..255, where y is the selected luma stream. With peak_en = 0, y_out = y[k].
- R9: The line delay is exactly LINE_LEN samples (default 910), and x samples before reset are taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one composite sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | W | Composite sample, unsigned |
| mode | input | 2 | 00 adaptive, 01 bandpass, 10 luma pass-through, 11 comb |
| peak_en | input | 1 | Enables luma peaking (ignored in bandpass mode) |
| thr | input | TW | Correlation threshold for adaptive mode |
| y_out | output | W | Luma sample, unsigned |
| c_out | output | W | Chroma sample, offset binary |

## Verification
The assertions check several things on every cycle once the mode has been held through a full latency window: the reset values, pass-through luma equal to the input delayed by the latency, bandpass luma equal to the clipped input minus the decoded chroma, and comb luma plus chroma equal to the delayed input or one less than it. The per-sample adaptive choice depends on the threshold and on the line-delayed data, so only the bench scenarios show it. The same holds for the exact bandpass and comb chroma values, the peaking arithmetic and its clipping, the line length and the cleared memory after reset. The bench builds these from video-like lines with inverted chroma, a luma step between lines, random data and full-scale bursts.

// File: rtl/yc_pkg.sv
package yc_pkg;
  typedef enum logic [1:0] {
    YC_ADAPT     = 2'b00,
    YC_BANDPASS  = 2'b01,
    YC_LUMA_THRU = 2'b10,
    YC_COMB      = 2'b11
  } yc_mode_e;

  localparam int YC_CORE_STAGES = 5;
endpackage

// File: rtl/yc_line_delay.sv
module yc_line_delay #(
  parameter int W   = 8,
  parameter int LEN = 910
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = $clog2(LEN);

  logic [W-1:0]  mem [LEN];
  logic [W-1:0]  rd_q;
  logic [AW-1:0] ptr;
  logic          wrapped;
  logic          rd_ok;

  // read-before-write port, block RAM friendly
  always_ff @(posedge clk) begin
    rd_q     <= mem[ptr];
    mem[ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      wrapped <= 1'b0;
      rd_ok   <= 1'b0;
    end else begin
      rd_ok <= wrapped;
      if (ptr == AW'(LEN - 1)) begin
        ptr     <= '0;
        wrapped <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // unwritten entries read as zero instead of clearing the whole array
  assign dout = rd_ok ? rd_q : '0;
endmodule

// File: rtl/yc_separate.sv
module yc_separate
  import yc_pkg::*;
#(
  parameter int W  = 8,
  parameter int TW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [W-1:0]        x_in,
  input  logic [W-1:0]        u_in,
  input  logic [1:0]          mode,
  input  logic [TW-1:0]       thr,
  output logic [W-1:0]        y_sel,
  output logic signed [W-1:0] c_sel
);
  localparam int SW = W + 4;

  logic [W-1:0] xs [0:4];
  logic [W-1:0] us [1:4];

  function automatic logic signed [SW-1:0] ext(input logic [W-1:0] a);
    return $signed({{(SW-W){1'b0}}, a});
  endfunction

  function automatic logic [W-1:0] sat(input logic signed [SW-1:0] v);
    if (v[SW-1]) return '0;
    if (v > $signed({{(SW-W){1'b0}}, {W{1'b1}}})) return '1;
    return v[W-1:0];
  endfunction

  logic signed [SW-1:0] xl, xc, xr, ul, uc, ur;
  logic signed [SW-1:0] comb_c, comb_y, bp_c, bp_sum;
  logic signed [SW-1:0] vl, vc, vr, lpv, lpv_abs, thr_s;
  logic [W-1:0]         bp_y;
  logic                 use_comb;
  logic [W-1:0]         y_nx;
  logic signed [SW-1:0] c_nx;

  always_comb begin
    xr = ext(xs[0]);
    xc = ext(xs[2]);
    xl = ext(xs[4]);
    ur = ext(u_in);
    uc = ext(us[2]);
    ul = ext(us[4]);
    comb_c  = (xc - uc) >>> 1;
    comb_y  = (xc + uc) >>> 1;
    bp_c    = ((xc <<< 1) - xl - xr) >>> 2;
    bp_sum  = xc - bp_c;
    bp_y    = sat(bp_sum);
    vl      = xl - ul;
    vc      = xc - uc;
    vr      = xr - ur;
    lpv     = (vl + (vc <<< 1) + vr) >>> 2;
    lpv_abs = lpv[SW-1] ? -lpv : lpv;
    thr_s   = $signed({{(SW-TW){1'b0}}, thr});
    use_comb = lpv_abs < thr_s;
    case (mode)
      YC_BANDPASS: begin
        y_nx = bp_y;
        c_nx = bp_c;
      end
      YC_COMB: begin
        y_nx = comb_y[W-1:0];
        c_nx = comb_c;
      end
      YC_LUMA_THRU: begin
        y_nx = xs[2];
        c_nx = use_comb ? comb_c : bp_c;
      end
      default: begin
        y_nx = use_comb ? comb_y[W-1:0] : bp_y;
        c_nx = use_comb ? comb_c : bp_c;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 5; i++) xs[i] <= '0;
      for (int i = 1; i < 5; i++) us[i] <= '0;
      y_sel <= '0;
      c_sel <= '0;
    end else begin
      xs[0] <= x_in;
      for (int i = 1; i < 5; i++) xs[i] <= xs[i-1];
      us[1] <= u_in;
      for (int i = 2; i < 5; i++) us[i] <= us[i-1];
      y_sel <= y_nx;
      c_sel <= c_nx[W-1:0];
    end
  end
endmodule

// File: rtl/yc_peak.sv
module yc_peak
  import yc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                peak_en,
  input  logic [1:0]          mode,
  input  logic [W-1:0]        y_sel,
  input  logic signed [W-1:0] c_sel,
  output logic [W-1:0]        y_pk,
  output logic [W-1:0]        c_pk
);
  localparam int SW = W + 4;

  logic [W-1:0]        yw1, yw2;
  logic signed [W-1:0] cw1;

  logic signed [SW-1:0] yl, yc, yr, hp, sum;
  logic [W-1:0]         y_nx;
  logic                 active;

  always_comb begin
    yr  = $signed({{(SW-W){1'b0}}, y_sel});
    yc  = $signed({{(SW-W){1'b0}}, yw1});
    yl  = $signed({{(SW-W){1'b0}}, yw2});
    hp  = ((yc <<< 1) - yl - yr) >>> 2;
    sum = yc + hp;
    active = peak_en && (mode != YC_BANDPASS);
    if (!active)                                          y_nx = yw1;
    else if (sum[SW-1])                                   y_nx = '0;
    else if (sum > $signed({{(SW-W){1'b0}}, {W{1'b1}}})) y_nx = '1;
    else                                                  y_nx = sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      yw1  <= '0;
      yw2  <= '0;
      cw1  <= '0;
      y_pk <= '0;
      c_pk <= {1'b1, {(W-1){1'b0}}};
    end else begin
      yw1  <= y_sel;
      yw2  <= yw1;
      cw1  <= c_sel;
      y_pk <= y_nx;
      c_pk <= {~cw1[W-1], cw1[W-2:0]};
    end
  end
endmodule

// File: rtl/yc_pipe_delay.sv
module yc_pipe_delay #(
  parameter int             W       = 8,
  parameter int             DEPTH   = 12,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign dout = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/yc_separator.sv
module yc_separator
  import yc_pkg::*;
#(
  parameter int W        = 8,
  parameter int LINE_LEN = 910,
  parameter int LATENCY  = 17,
  parameter int TW       = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  x_in,
  input  logic [1:0]    mode,
  input  logic          peak_en,
  input  logic [TW-1:0] thr,
  output logic [W-1:0]  y_out,
  output logic [W-1:0]  c_out
);
  localparam int PAD = LATENCY - YC_CORE_STAGES;
  localparam logic [W-1:0] C_ZERO = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]        line_q;
  logic [W-1:0]        ysel;
  logic signed [W-1:0] csel;
  logic [W-1:0]        ypk, cpk;

  yc_line_delay #(.W(W), .LEN(LINE_LEN)) u_line (
    .clk(clk), .rst(rst), .din(x_in), .dout(line_q)
  );

  yc_separate #(.W(W), .TW(TW)) u_sep (
    .clk(clk), .rst(rst), .x_in(x_in), .u_in(line_q),
    .mode(mode), .thr(thr), .y_sel(ysel), .c_sel(csel)
  );

  yc_peak #(.W(W)) u_peak (
    .clk(clk), .rst(rst), .peak_en(peak_en), .mode(mode),
    .y_sel(ysel), .c_sel(csel), .y_pk(ypk), .c_pk(cpk)
  );

  yc_pipe_delay #(.W(W), .DEPTH(PAD), .RST_VAL('0)) u_ydly (
    .clk(clk), .rst(rst), .din(ypk), .dout(y_out)
  );

  yc_pipe_delay #(.W(W), .DEPTH(PAD), .RST_VAL(C_ZERO)) u_cdly (
    .clk(clk), .rst(rst), .din(cpk), .dout(c_out)
  );
endmodule

// File: rtl/yc_separator_chk.sv
module yc_separator_chk #(
  parameter int W       = 8,
  parameter int LATENCY = 17
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] x_in,
  input logic [1:0]   mode,
  input logic         peak_en,
  input logic [W-1:0] y_out,
  input logic [W-1:0] c_out
);
  localparam int CW   = $clog2(LATENCY + 2);
  localparam int HALF = 1 << (W - 1);
  localparam int MAXV = (1 << W) - 1;

  logic [W-1:0]  xh [0:LATENCY];
  logic [CW-1:0] calm = '0;
  logic [1:0]    mode_q = 2'b00;
  logic          peak_q = 1'b0;
  logic          rst_q  = 1'b0;
  logic          settled;

  always_ff @(posedge clk) begin
    xh[0] <= x_in;
    for (int i = 1; i <= LATENCY; i++) xh[i] <= xh[i-1];
    mode_q <= mode;
    peak_q <= peak_en;
    rst_q  <= rst;
    if (rst || mode != mode_q || peak_en != peak_q) calm <= '0;
    else if (calm != CW'(LATENCY + 1))              calm <= calm + 1'b1;
  end

  assign settled = (calm == CW'(LATENCY + 1));

  int xo, yo, co, bpy;
  assign xo  = int'(xh[LATENCY]);
  assign yo  = int'(y_out);
  assign co  = int'(c_out) - HALF;
  assign bpy = (xo - co < 0) ? 0 : ((xo - co > MAXV) ? MAXV : xo - co);

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_VALUES: assert (y_out == '0 && c_out == W'(HALF)); // R1
    end
  end

  AST_THRU_LUMA_DELAY: assert property (@(posedge clk) disable iff (rst)
    (settled && mode == 2'b10 && !peak_en) |-> (yo == xo)); // R6

  AST_BANDPASS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    (settled && mode == 2'b01) |-> (yo == bpy)); // R4

  AST_COMB_SUM: assert property (@(posedge clk) disable iff (rst)
    (settled && mode == 2'b11 && !peak_en) |-> ((yo + co == xo) || (yo + co == xo - 1))); // R5
endmodule

bind yc_separator yc_separator_chk #(.W(W), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst(rst), .x_in(x_in), .mode(mode), .peak_en(peak_en),
  .y_out(y_out), .c_out(c_out)
);

// File: tb/sim_yc_separator.sv
module sim_yc_separator;
  localparam int LLEN = 24;
  localparam int LAT  = 17;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] x_in = '0;
  logic [7:0] thr = '0;
  logic [1:0] mode = 2'b00;
  logic       peak_en = 1'b0;
  logic [7:0] y_out, c_out;

  yc_separator #(.W(8), .LINE_LEN(LLEN), .LATENCY(LAT), .TW(8)) u0 (
    .clk(clk), .rst(rst), .x_in(x_in), .mode(mode), .peak_en(peak_en),
    .thr(thr), .y_out(y_out), .c_out(c_out)
  );

  always #4 clk = ~clk;

  typedef struct {int k; int y; int c; string tag;} exp_t;
  exp_t sb[$];
  exp_t e;

  int stim [0:511];
  int n_stim;
  int cur_mode, cur_thr;
  bit cur_pk;
  int ecnt = 0, checks = 0, fails = 0;
  int unsigned seed = 32'h1234_5678;

  function automatic int sat(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction
  function automatic int xv(int i);
    return (i < 0 || i >= n_stim) ? 0 : stim[i];
  endfunction
  function automatic int uv(int i);
    return xv(i - LLEN);
  endfunction
  function automatic int comb_c(int m); return (xv(m) - uv(m)) >>> 1; endfunction
  function automatic int comb_y(int m); return (xv(m) + uv(m)) >>> 1; endfunction
  function automatic int bp_c(int m); return (2*xv(m) - xv(m-2) - xv(m+2)) >>> 2; endfunction
  function automatic int bp_y(int m); return sat(xv(m) - bp_c(m)); endfunction
  function automatic int vd(int i); return xv(i) - uv(i); endfunction
  function automatic bit corr(int m);
    int v;
    v = (vd(m-2) + 2*vd(m) + vd(m+2)) >>> 2;
    if (v < 0) v = -v;
    return v < cur_thr;
  endfunction
  function automatic int pre_y(int m);
    case (cur_mode)
      1: return bp_y(m);
      2: return xv(m);
      3: return comb_y(m);
      default: return corr(m) ? comb_y(m) : bp_y(m);
    endcase
  endfunction
  function automatic int pre_c(int m);
    case (cur_mode)
      1: return bp_c(m);
      3: return comb_c(m);
      default: return corr(m) ? comb_c(m) : bp_c(m);
    endcase
  endfunction
  function automatic int fin_y(int k);
    if (cur_pk && cur_mode != 1)
      return sat(pre_y(k) + ((2*pre_y(k) - pre_y(k-1) - pre_y(k+1)) >>> 2));
    return pre_y(k);
  endfunction

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  task automatic gen_random(input int n);
    n_stim = n;
    for (int i = 0; i < n; i++) stim[i] = rnd();
  endtask

  task automatic gen_video(input int n, input int amp, input int b1, input int b2, input int sw_line);
    n_stim = n;
    for (int i = 0; i < n; i++) begin
      int p, ln;
      ln = i / LLEN;
      p = (i % 4 == 1) ? amp : ((i % 4 == 3) ? -amp : 0);
      if (ln % 2 == 1) p = -p;
      stim[i] = sat(((ln < sw_line) ? b1 : b2) + p);
    end
  endtask

  task automatic gen_bursts(input int n, input int run);
    n_stim = n;
    for (int i = 0; i < n; i++) stim[i] = ((i / run) % 2 == 0) ? 255 : 0;
  endtask

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) ecnt <= rst ? 0 : ecnt + 1;

  // monitor: pops the scoreboard when the item's output cycle is reached
  always @(negedge clk) begin
    if (!rst && sb.size() > 0 && sb[0].k == ecnt - 1 - LAT) begin
      e = sb.pop_front();
      check(int'(y_out) == e.y, e.tag, $sformatf("y k=%0d", e.k), int'(y_out), e.y);
      check(int'(c_out) == e.c, e.tag, $sformatf("c k=%0d", e.k), int'(c_out), e.c);
    end
  end

  // driver: reset, push the expected results, then stream the samples
  task automatic run(input int md, input bit pk, input int th, input string tag);
    @(negedge clk);
    rst = 1'b1; x_in = '0;
    cur_mode = md; cur_pk = pk; cur_thr = th;
    mode = 2'(md); peak_en = pk; thr = 8'(th);
    repeat (3) @(negedge clk);
    check(y_out == 8'd0, "R1", "reset y", int'(y_out), 0);
    check(c_out == 8'd128, "R1", "reset c", int'(c_out), 128);
    for (int k = 0; k < n_stim; k++)
      sb.push_back('{k, fin_y(k), pre_c(k) + 128, tag});
    x_in = 8'(xv(0));
    rst = 1'b0;
    for (int i = 1; i < n_stim + LAT + 8; i++) begin
      @(negedge clk);
      x_in = 8'(xv(i));
    end
    check(sb.size() == 0, tag, "scoreboard left", sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    gen_video(100, 40, 120, 60, 3);
    run(2, 1'b0, 16, "R6/R2");
    gen_random(96);
    run(1, 1'b1, 16, "R4/R3/R8");
    gen_video(100, 40, 120, 60, 3);
    run(3, 1'b0, 0, "R5/R9/R1");
    gen_video(110, 40, 120, 60, 3);
    run(0, 1'b0, 20, "R7");
    gen_random(80);
    run(0, 1'b0, 0, "R7");
    gen_random(80);
    run(0, 1'b0, 255, "R7");
    gen_random(90);
    run(3, 1'b1, 0, "R8");
    gen_bursts(80, 5);
    run(2, 1'b1, 16, "R8");
    gen_bursts(80, 2);
    run(1, 1'b0, 0, "R4");
    gen_video(100, 50, 200, 30, 2);
    run(0, 1'b1, 30, "R7/R8");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule